// File: doc/BRIEF.md
# Banked CPU Register File with Single-Cycle Exchanges

This block is the architectural register file of an 8-bit processor core. It holds the accumulator, the flag byte and six general bytes (three 16-bit pairs), with a second copy of all eight. It also holds two 16-bit index registers and a stack pointer. Reads are combinational. At most one write is accepted per clock, through one of three ports: an 8-bit port addressed by the core's 3-bit register code, a port for the halves of the index registers, or a 16-bit pair port. The pair port loads a value or steps the pair by one.

Three exchange strobes rearrange register contents in a single clock. No data is moved. One select bit chooses the active accumulator/flag copy. A second select bit chooses the active general bank. A per-bank bit swaps the roles of the DE and HL storage slots. The pair port decodes its 2-bit code in one of two ways: a stack mapping, where the top code means AF, or an arithmetic mapping, where the top code means SP and an index prefix can redirect HL to IX or IY. Some input combinations have no defined meaning. The block flags these on `illegal_o` and discards the whole cycle.

Top module: `cpu_regfile`

## Requirements
- R1: After reset every register in both copies reads zero, both copy selects are on the primary copy, and no DE/HL swap is in effect.
- R2: The 8-bit code selects B=000, C=001, D=010, E=011, H=100, L=101, A=111. Code 110 names no register. It reads as zero, and a write to it changes nothing.
- R3: The half-index code {i,b} selects 00=IX high, 01=IX low, 10=IY high, 11=IY low, for both reads and writes.
- R4: With `pr_map_i`=0 (stack mapping), pair codes 00/01/10/11 select BC/DE/HL/AF. AF puts A in the high byte and F in the low byte.
- R5: With `pr_map_i`=1 (arithmetic mapping), code 11 selects SP. When `idx_en_i`=1, code 10 selects IX (`idx_sel_i`=0) or IY (`idx_sel_i`=1) in place of HL. The prefix has no effect in the stack mapping.
- R6: `pr_op_i` encodes 00=none, 01=load `pr_wdata_i`, 10=increment, 11=decrement, on the selected pair. Stepping wraps modulo 2^16 and leaves F unchanged unless F is part of the target.
- R7: `x_af_i` exchanges A and F with their alternates and touches no other register. Two exchanges restore the original view.
- R8: `x_bank_i` exchanges BC, DE and HL with their alternates together and leaves A and F unchanged.
- R9: `x_dehl_i` exchanges DE and HL in the active bank only. The swap state of the other bank is preserved.
- R10: `illegal_o` is high, combinationally, when more than one write port is active, when a write coincides with any exchange, or when `x_bank_i` and `x_dehl_i` coincide. Such a cycle changes no register and no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| r8_rsel_i | input | 3 | 8-bit read code |
| r8_rdata_o | output | 8 | 8-bit read data |
| r8_we_i | input | 1 | 8-bit write enable |
| r8_wsel_i | input | 3 | 8-bit write code |
| r8_wdata_i | input | 8 | 8-bit write data |
| hx_rsel_i | input | 2 | Half-index read code {i,b} |
| hx_rdata_o | output | 8 | Half-index read data |
| hx_we_i | input | 1 | Half-index write enable |
| hx_wsel_i | input | 2 | Half-index write code {i,b} |
| hx_wdata_i | input | 8 | Half-index write data |
| pr_map_i | input | 1 | Pair mapping: 0 stack, 1 arithmetic |
| idx_en_i | input | 1 | Index prefix active (arithmetic mapping) |
| idx_sel_i | input | 1 | Prefix target: 0 IX, 1 IY |
| pr_sel_i | input | 2 | Pair code for read and pair operation |
| pr_rdata_o | output | 16 | Pair read data |
| pr_op_i | input | 2 | Pair operation: none, load, increment, decrement |
| pr_wdata_i | input | 16 | Pair load data |
| x_af_i | input | 1 | Exchange AF with alternate |
| x_bank_i | input | 1 | Exchange BC/DE/HL with alternates |
| x_dehl_i | input | 1 | Exchange DE and HL in active bank |
| illegal_o | output | 1 | Current input combination is illegal |

## Verification
The bench keeps an architectural model in which the DE/HL exchange physically moves bytes. A design that toggled the swap bit of the wrong bank, or applied the swap globally, therefore diverges as soon as a bank exchange follows a DE/HL exchange. Every read code in every mapping and prefix variant is swept after each operation. This exposes a misplaced code 110, an HL that is not redirected under the prefix, and a prefix that leaks into the stack mapping. Increments at 0xFFFF and decrements at 0x0000 expose a broken wrap. Writes combined with exchanges show whether a colliding cycle leaks a partial update.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [2:0] {WK_NONE, WK_AF, WK_GP, WK_IX, WK_IY, WK_SP} wkind_e;
  typedef enum logic [1:0] {PO_NONE, PO_LOAD, PO_INC, PO_DEC} pair_op_e;
  localparam logic [2:0] R8_A    = 3'b111;
  localparam logic [2:0] R8_VOID = 3'b110;
  localparam logic [1:0] PR_HL   = 2'b10;
  localparam logic [1:0] PR_TOP  = 2'b11;
  localparam int NGP = 3;  // BC, DE, HL
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_af_i,
  input  logic x_bank_i,
  input  logic x_dehl_i,
  input  logic block_i,
  output logic af_sel_o,
  output logic gp_sel_o,
  output logic swp_act_o
);
  logic       af_sel_q, gp_sel_q;
  logic [1:0] swp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_sel_q <= 1'b0;
      gp_sel_q <= 1'b0;
      swp_q    <= '0;
    end else if (!block_i) begin
      if (x_af_i)   af_sel_q <= ~af_sel_q;
      if (x_bank_i) gp_sel_q <= ~gp_sel_q;
      if (x_dehl_i) swp_q[gp_sel_q] <= ~swp_q[gp_sel_q];
    end
  end

  assign af_sel_o  = af_sel_q;
  assign gp_sel_o  = gp_sel_q;
  assign swp_act_o = swp_q[gp_sel_q];

  a_r7_af_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_af_i && !block_i) |=> (af_sel_q != $past(af_sel_q)));
  a_r8_bank_keeps_af: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_bank_i && !x_af_i && !block_i) |=> ($stable(af_sel_q) && gp_sel_q != $past(gp_sel_q)));
  a_r9_dehl_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_dehl_i && !block_i) |=> ($stable(gp_sel_q) && $countones(swp_q ^ $past(swp_q)) == 1));
  a_r10_block_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> ($stable(af_sel_q) && $stable(gp_sel_q) && $stable(swp_q)));
endmodule

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    af_sel_i,
  input  logic                    gp_sel_i,
  input  wkind_e                  wk_i,
  input  logic [1:0]              gp_idx_i,
  input  logic                    we_hi_i,
  input  logic                    we_lo_i,
  input  logic [PW-1:0]           wdata_i,
  output logic [DW-1:0]           a_o,
  output logic [DW-1:0]           f_o,
  output logic [NGP-1:0][PW-1:0]  gp_o,
  output logic [PW-1:0]           ix_o,
  output logic [PW-1:0]           iy_o,
  output logic [PW-1:0]           sp_o
);
  logic [1:0][DW-1:0]          a_q, f_q;
  logic [1:0][NGP-1:0][PW-1:0] gp_q;
  logic [PW-1:0]               ix_q, iy_q, sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      f_q  <= '0;
      gp_q <= '0;
      ix_q <= '0;
      iy_q <= '0;
      sp_q <= '0;
    end else begin
      case (wk_i)
        WK_AF: begin
          if (we_hi_i) a_q[af_sel_i] <= wdata_i[PW-1:DW];
          if (we_lo_i) f_q[af_sel_i] <= wdata_i[DW-1:0];
        end
        WK_GP: if (int'(gp_idx_i) < NGP) begin
          if (we_hi_i) gp_q[gp_sel_i][gp_idx_i][PW-1:DW] <= wdata_i[PW-1:DW];
          if (we_lo_i) gp_q[gp_sel_i][gp_idx_i][DW-1:0]  <= wdata_i[DW-1:0];
        end
        WK_IX: begin
          if (we_hi_i) ix_q[PW-1:DW] <= wdata_i[PW-1:DW];
          if (we_lo_i) ix_q[DW-1:0]  <= wdata_i[DW-1:0];
        end
        WK_IY: begin
          if (we_hi_i) iy_q[PW-1:DW] <= wdata_i[PW-1:DW];
          if (we_lo_i) iy_q[DW-1:0]  <= wdata_i[DW-1:0];
        end
        WK_SP: begin
          if (we_hi_i) sp_q[PW-1:DW] <= wdata_i[PW-1:DW];
          if (we_lo_i) sp_q[DW-1:0]  <= wdata_i[DW-1:0];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp_view
    assign gp_o[g] = gp_q[gp_sel_i][g];
  end
  assign a_o  = a_q[af_sel_i];
  assign f_o  = f_q[af_sel_i];
  assign ix_o = ix_q;
  assign iy_o = iy_q;
  assign sp_o = sp_q;

  a_r10_idle_keeps_16b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wk_i == WK_NONE) |=> ($stable(ix_q) && $stable(iy_q) && $stable(sp_q) && $stable(gp_q)));
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import rf_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    r8_rsel_i,
  output logic [DW-1:0] r8_rdata_o,
  input  logic          r8_we_i,
  input  logic [2:0]    r8_wsel_i,
  input  logic [DW-1:0] r8_wdata_i,
  input  logic [1:0]    hx_rsel_i,
  output logic [DW-1:0] hx_rdata_o,
  input  logic          hx_we_i,
  input  logic [1:0]    hx_wsel_i,
  input  logic [DW-1:0] hx_wdata_i,
  input  logic          pr_map_i,
  input  logic          idx_en_i,
  input  logic          idx_sel_i,
  input  logic [1:0]    pr_sel_i,
  output logic [PW-1:0] pr_rdata_o,
  input  logic [1:0]    pr_op_i,
  input  logic [PW-1:0] pr_wdata_i,
  input  logic          x_af_i,
  input  logic          x_bank_i,
  input  logic          x_dehl_i,
  output logic          illegal_o
);
  logic                   af_sel, gp_sel, swp_act;
  logic [DW-1:0]          a_v, f_v;
  logic [NGP-1:0][PW-1:0] gp_v;
  logic [PW-1:0]          ix_v, iy_v, sp_v;
  wkind_e                 wk;
  logic [1:0]             gp_idx;
  logic                   we_hi, we_lo;
  logic [PW-1:0]          wdata;
  pair_op_e               pop;
  logic [1:0]             nwr;
  logic                   idx_hit;

  // logical pair (0 BC, 1 DE, 2 HL) to storage slot under the active swap bit
  function automatic logic [1:0] slot(input logic [1:0] lp, input logic swp);
    return (swp && lp != 2'd0) ? (lp ^ 2'b11) : lp;
  endfunction

  assign pop     = pair_op_e'(pr_op_i);
  assign nwr     = {1'b0, r8_we_i} + {1'b0, hx_we_i} + {1'b0, pop != PO_NONE};
  assign illegal_o = (nwr > 2'd1) || ((nwr != 2'd0) && (x_af_i || x_bank_i || x_dehl_i))
                   || (x_bank_i && x_dehl_i);
  assign idx_hit = pr_map_i && idx_en_i && (pr_sel_i == PR_HL);

  always_comb begin
    logic [PW-1:0] pv;
    pv = gp_v[slot(r8_rsel_i[2:1], swp_act)];
    if (r8_rsel_i == R8_A)         r8_rdata_o = a_v;
    else if (r8_rsel_i == R8_VOID) r8_rdata_o = '0;
    else r8_rdata_o = r8_rsel_i[0] ? pv[DW-1:0] : pv[PW-1:DW];
  end

  always_comb begin
    logic [PW-1:0] xv;
    xv = hx_rsel_i[1] ? iy_v : ix_v;
    hx_rdata_o = hx_rsel_i[0] ? xv[DW-1:0] : xv[PW-1:DW];
  end

  always_comb begin
    if (idx_hit)                 pr_rdata_o = idx_sel_i ? iy_v : ix_v;
    else if (pr_sel_i == PR_TOP) pr_rdata_o = pr_map_i ? sp_v : {a_v, f_v};
    else                         pr_rdata_o = gp_v[slot(pr_sel_i, swp_act)];
  end

  always_comb begin
    wk     = WK_NONE;
    gp_idx = '0;
    we_hi  = 1'b0;
    we_lo  = 1'b0;
    wdata  = '0;
    if (!illegal_o) begin
      if (r8_we_i) begin
        wdata = {r8_wdata_i, r8_wdata_i};
        if (r8_wsel_i == R8_A) begin
          wk    = WK_AF;
          we_hi = 1'b1;
        end else if (r8_wsel_i != R8_VOID) begin
          wk     = WK_GP;
          gp_idx = slot(r8_wsel_i[2:1], swp_act);
          we_hi  = ~r8_wsel_i[0];
          we_lo  = r8_wsel_i[0];
        end
      end else if (hx_we_i) begin
        wk    = hx_wsel_i[1] ? WK_IY : WK_IX;
        we_hi = ~hx_wsel_i[0];
        we_lo = hx_wsel_i[0];
        wdata = {hx_wdata_i, hx_wdata_i};
      end else if (pop != PO_NONE) begin
        we_hi  = 1'b1;
        we_lo  = 1'b1;
        gp_idx = slot(pr_sel_i, swp_act);
        case (pop)
          PO_INC:  wdata = pr_rdata_o + PW'(1);
          PO_DEC:  wdata = pr_rdata_o - PW'(1);
          default: wdata = pr_wdata_i;
        endcase
        if (idx_hit)                 wk = idx_sel_i ? WK_IY : WK_IX;
        else if (pr_sel_i == PR_TOP) wk = pr_map_i ? WK_SP : WK_AF;
        else                         wk = WK_GP;
      end
    end
  end

  rf_bank_ctrl i_bank_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x_af_i    (x_af_i),
    .x_bank_i  (x_bank_i),
    .x_dehl_i  (x_dehl_i),
    .block_i   (illegal_o),
    .af_sel_o  (af_sel),
    .gp_sel_o  (gp_sel),
    .swp_act_o (swp_act)
  );

  rf_store #(.DW(DW)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .af_sel_i (af_sel),
    .gp_sel_i (gp_sel),
    .wk_i     (wk),
    .gp_idx_i (gp_idx),
    .we_hi_i  (we_hi),
    .we_lo_i  (we_lo),
    .wdata_i  (wdata),
    .a_o      (a_v),
    .f_o      (f_v),
    .gp_o     (gp_v),
    .ix_o     (ix_v),
    .iy_o     (iy_v),
    .sp_o     (sp_v)
  );

  a_r6_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pop == PO_INC || pop == PO_DEC) && !illegal_o && !(!pr_map_i && pr_sel_i == PR_TOP))
    |=> (f_v == $past(f_v)));
  a_r10_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> ($stable(a_v) && $stable(f_v) && $stable(ix_v) && $stable(iy_v) && $stable(sp_v)));
endmodule

// File: tb/test_cpu_regfile.sv
module test_cpu_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  r8_rsel = '0, r8_wsel = '0;
  logic [7:0]  r8_rdata, r8_wdata = '0;
  logic        r8_we = 1'b0;
  logic [1:0]  hx_rsel = '0, hx_wsel = '0;
  logic [7:0]  hx_rdata, hx_wdata = '0;
  logic        hx_we = 1'b0;
  logic        pr_map = 1'b0, idx_en = 1'b0, idx_sel = 1'b0;
  logic [1:0]  pr_sel = '0, pr_op = '0;
  logic [15:0] pr_rdata, pr_wdata = '0;
  logic        x_af = 1'b0, x_bank = 1'b0, x_dehl = 1'b0;
  logic        illegal;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  // architectural model: DE/HL exchange moves bytes
  logic [7:0]  mreg [2][6];
  logic [7:0]  ma [2];
  logic [7:0]  mf [2];
  logic [15:0] mix, miy, msp;
  int          cab, cgb;

  always #5 clk = ~clk;

  cpu_regfile i_cpu_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .r8_rsel_i(r8_rsel), .r8_rdata_o(r8_rdata),
    .r8_we_i(r8_we), .r8_wsel_i(r8_wsel), .r8_wdata_i(r8_wdata),
    .hx_rsel_i(hx_rsel), .hx_rdata_o(hx_rdata),
    .hx_we_i(hx_we), .hx_wsel_i(hx_wsel), .hx_wdata_i(hx_wdata),
    .pr_map_i(pr_map), .idx_en_i(idx_en), .idx_sel_i(idx_sel),
    .pr_sel_i(pr_sel), .pr_rdata_o(pr_rdata),
    .pr_op_i(pr_op), .pr_wdata_i(pr_wdata),
    .x_af_i(x_af), .x_bank_i(x_bank), .x_dehl_i(x_dehl),
    .illegal_o(illegal)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] e8(input int c);
    if (c == 7) return ma[cab];
    if (c == 6) return 8'h00;
    return mreg[cgb][c];
  endfunction

  function automatic logic [15:0] e16(input logic m, input logic ie, input logic is, input int s);
    if (m && ie && s == 2) return is ? miy : mix;
    if (s == 3) return m ? msp : {ma[cab], mf[cab]};
    return {mreg[cgb][2*s], mreg[cgb][2*s+1]};
  endfunction

  task automatic set16(input logic m, input logic ie, input logic is, input int s, input logic [15:0] v);
    if (m && ie && s == 2) begin
      if (is) miy = v; else mix = v;
    end else if (s == 3) begin
      if (m) msp = v; else begin ma[cab] = v[15:8]; mf[cab] = v[7:0]; end
    end else begin
      mreg[cgb][2*s] = v[15:8]; mreg[cgb][2*s+1] = v[7:0];
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 8; c++) begin
      r8_rsel = 3'(c); #1;
      chk(tag, $sformatf("r8 code %0d", c), 32'(r8_rdata), 32'(e8(c)));
    end
    for (int h = 0; h < 4; h++) begin
      logic [15:0] xv;
      hx_rsel = 2'(h); #1;
      xv = h[1] ? miy : mix;
      chk(tag, $sformatf("half-index %0d", h), 32'(hx_rdata), 32'(h[0] ? xv[7:0] : xv[15:8]));
    end
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 3; v++) begin
          pr_map = m[0]; pr_sel = 2'(s); idx_en = (v != 0); idx_sel = (v == 2); #1;
          chk(tag, $sformatf("pair map%0d sel%0d pfx%0d", m, s, v), 32'(pr_rdata),
              32'(e16(m[0], idx_en, idx_sel, s)));
        end
    pr_map = 1'b0; pr_sel = '0; idx_en = 1'b0; idx_sel = 1'b0;
  endtask

  task automatic do_op(input logic rw, input logic [2:0] rs, input logic [7:0] rd,
                       input logic hw, input logic [1:0] hs, input logic [7:0] hd,
                       input logic m, input logic ie, input logic is, input logic [1:0] s,
                       input logic [1:0] op, input logic [15:0] pd,
                       input logic xa, input logic xb, input logic xd);
    int nw;
    logic ill;
    logic [15:0] pv;
    @(negedge clk);
    r8_we = rw; r8_wsel = rs; r8_wdata = rd;
    hx_we = hw; hx_wsel = hs; hx_wdata = hd;
    pr_map = m; idx_en = ie; idx_sel = is; pr_sel = s; pr_op = op; pr_wdata = pd;
    x_af = xa; x_bank = xb; x_dehl = xd;
    nw  = int'(rw) + int'(hw) + int'(op != 2'b00);
    ill = (nw > 1) || (nw > 0 && (xa || xb || xd)) || (xb && xd);
    #1;
    chk("R10", "illegal flag", 32'(illegal), 32'(ill));
    pv = e16(m, ie, is, int'(s));
    @(posedge clk); #1;
    r8_we = 1'b0; hx_we = 1'b0; pr_op = '0; x_af = 1'b0; x_bank = 1'b0; x_dehl = 1'b0;
    pr_map = 1'b0; idx_en = 1'b0; idx_sel = 1'b0; pr_sel = '0;
    if (!ill) begin
      if (rw) begin
        if (rs == 3'd7) ma[cab] = rd;
        else if (rs != 3'd6) mreg[cgb][rs] = rd;
      end
      if (hw) begin
        if (hs[1]) begin if (hs[0]) miy[7:0] = hd; else miy[15:8] = hd; end
        else       begin if (hs[0]) mix[7:0] = hd; else mix[15:8] = hd; end
      end
      case (op)
        2'b01: set16(m, ie, is, int'(s), pd);
        2'b10: set16(m, ie, is, int'(s), pv + 16'd1);
        2'b11: set16(m, ie, is, int'(s), pv - 16'd1);
        default: ;
      endcase
      if (xa) cab ^= 1;
      if (xb) cgb ^= 1;
      if (xd) begin
        logic [7:0] t0, t1;
        t0 = mreg[cgb][2]; t1 = mreg[cgb][3];
        mreg[cgb][2] = mreg[cgb][4]; mreg[cgb][3] = mreg[cgb][5];
        mreg[cgb][4] = t0; mreg[cgb][5] = t1;
      end
    end
  endtask

  task automatic w8(input int c, input logic [7:0] d);
    do_op(1'b1, 3'(c), d, 1'b0, 2'b0, 8'h0, 1'b0, 1'b0, 1'b0, 2'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic whx(input int h, input logic [7:0] d);
    do_op(1'b0, 3'b0, 8'h0, 1'b1, 2'(h), d, 1'b0, 1'b0, 1'b0, 2'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic pop16(input logic m, input logic ie, input logic is, input int s,
                       input logic [1:0] op, input logic [15:0] d);
    do_op(1'b0, 3'b0, 8'h0, 1'b0, 2'b0, 8'h0, m, ie, is, 2'(s), op, d, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic xchg(input logic xa, input logic xb, input logic xd);
    do_op(1'b0, 3'b0, 8'h0, 1'b0, 2'b0, 8'h0, 1'b0, 1'b0, 1'b0, 2'b0, 2'b00, 16'h0, xa, xb, xd);
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      ma[b] = '0; mf[b] = '0;
      for (int r = 0; r < 6; r++) mreg[b][r] = '0;
    end
    mix = '0; miy = '0; msp = '0; cab = 0; cgb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "illegal after reset", 32'(illegal), 32'h0);
    check_all("R1");

    // R2: every 8-bit code, including the void code 110
    for (int c = 0; c < 8; c++) w8(c, 8'h11 * 8'(c + 1));
    check_all("R2");
    // R3: each index half
    for (int h = 0; h < 4; h++) whx(h, 8'hA0 + 8'(h));
    check_all("R3");
    // R4: AF through stack mapping
    pop16(1'b0, 1'b0, 1'b0, 3, 2'b01, 16'h5AC3);
    check_all("R4");
    // R5: SP, prefix redirect, prefix ignored in stack mapping
    pop16(1'b1, 1'b0, 1'b0, 3, 2'b01, 16'hBEEF);
    pop16(1'b1, 1'b1, 1'b0, 2, 2'b01, 16'h1234);
    pop16(1'b1, 1'b1, 1'b1, 2, 2'b01, 16'h4321);
    pop16(1'b0, 1'b1, 1'b1, 2, 2'b01, 16'h7788);
    check_all("R5");
    // R6: wrap at both ends on every arithmetic target
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 3; v++) begin
        if (v != 0 && s != 2) continue;
        pop16(1'b1, v != 0, v == 2, s, 2'b01, 16'hFFFF);
        pop16(1'b1, v != 0, v == 2, s, 2'b10, 16'h0);
        check_all("R6");
        pop16(1'b1, v != 0, v == 2, s, 2'b11, 16'h0);
        check_all("R6");
      end
    // R7: alternate AF
    xchg(1'b1, 1'b0, 1'b0);
    check_all("R7");
    w8(7, 8'h9C);
    pop16(1'b0, 1'b0, 1'b0, 3, 2'b01, 16'h3355);
    xchg(1'b1, 1'b0, 1'b0);
    check_all("R7");
    // R8: alternate bank, AF untouched
    xchg(1'b0, 1'b1, 1'b0);
    check_all("R8");
    for (int c = 0; c < 6; c++) w8(c, 8'hC0 + 8'(c));
    check_all("R8");
    // R9: DE/HL swap in one bank, then the other stays unswapped
    xchg(1'b0, 1'b0, 1'b1);
    check_all("R9");
    xchg(1'b0, 1'b1, 1'b0);
    check_all("R9");
    w8(2, 8'h5D);
    xchg(1'b0, 1'b1, 1'b0);
    pop16(1'b0, 1'b0, 1'b0, 1, 2'b10, 16'h0);
    check_all("R9");
    // R10: collisions leave everything untouched
    do_op(1'b1, 3'd7, 8'hEE, 1'b0, 2'b0, 8'h0, 1'b0, 1'b0, 1'b0, 2'b0, 2'b00, 16'h0, 1'b1, 1'b0, 1'b0);
    check_all("R10");
    do_op(1'b1, 3'd0, 8'hEE, 1'b1, 2'd0, 8'hEE, 1'b0, 1'b0, 1'b0, 2'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);
    check_all("R10");
    do_op(1'b0, 3'd0, 8'h0, 1'b0, 2'd0, 8'h0, 1'b1, 1'b0, 1'b0, 2'd3, 2'b10, 16'h0, 1'b0, 1'b0, 1'b1);
    check_all("R10");
    xchg(1'b0, 1'b1, 1'b1);
    check_all("R10");
    // mixed legal traffic
    for (int k = 0; k < 300; k++) begin
      int sel;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: w8(int'($urandom_range(0, 7)), 8'($urandom));
        1: whx(int'($urandom_range(0, 3)), 8'($urandom));
        2: pop16(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                 2'($urandom_range(1, 3)), 16'($urandom));
        3: xchg(1'($urandom), 1'b1, 1'b0);
        4: xchg(1'($urandom), 1'b0, 1'b1);
        default: xchg(1'b1, 1'b0, 1'b0);
      endcase
      check_all("R2");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule